// File: doc/BRIEF.md
# Limited-Range Pixel Clamp

This block sits in a display output pipeline and limits every colour component of a streamed pixel to a legal window. Each pixel carries three 12-bit components. A 3-bit format code selects the window: one of three fixed limited-video windows for 8, 10 or 12 bits per component, a window set separately for each channel, or no clamping at all. A clamp enable overrides the code. When the enable is low, pixels pass through untouched.

The per-channel bounds live in bound registers inside the block. They are loaded from the bound input ports by a one-cycle load strobe and return to their defaults on reset. Pixels travel through a single output register. The output valid follows the input valid one cycle later. While no valid pixel arrives, the output data keeps its last value.

Decoding uses five named modes. PASS covers enable low and codes 0 and 4 to 6. FIX8, FIX10 and FIX12 cover codes 1, 2 and 3. PROG covers code 7. The mode is re-decoded every cycle from the current inputs, so there are no transitions to sequence. A new mode applies to the very next pixel presented.

Top module: `pixel_range_clamp`

## Requirements
- R1: With the enable high and format code 0, each output pixel equals the input pixel presented one cycle earlier.
- R2: With the enable high, format codes 1, 2 and 3 clamp every component to a lower bound of 0x100 and an upper bound of 0xEB0, 0xEBC and 0xEBF respectively.
- R3: With the enable high and format code 7, each channel is clamped to its own bound registers. The bound registers are loaded from prog_lo and prog_hi in the cycle prog_load is high, and the new bounds apply to pixels presented from the next cycle on.
- R4: After reset, every programmable lower bound is 0x010 and every upper bound is 0xFEF.
- R5: With the enable low, the pixel passes through unchanged whatever the format code.
- R6: Format codes 4, 5 and 6 pass the pixel through unchanged.
- R7: A component below its lower bound becomes the lower bound, and a component above its upper bound becomes the upper bound. Any other component is unchanged. The lower bound is tested first, so if the lower bound is greater than the upper bound, a component below the lower bound takes the lower bound and any other component above the upper bound takes the upper bound.
- R8: Packed pixels place R in bits 35:24, G in bits 23:12 and B in bits 11:0, and bound ports use the same layout. out_valid equals in_valid delayed by one cycle, and reset clears out_valid and out_pix to zero.
- R9: In a cycle with in_valid low, out_pix keeps its previous value in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel is valid |
| in_pix | input | 36 | Input pixel, R/G/B packed |
| clamp_en | input | 1 | Clamp enable; low forces pass-through |
| fmt_code | input | 3 | Window select code |
| prog_load | input | 1 | Load strobe for the programmable bounds |
| prog_lo | input | 36 | Programmable lower bounds, R/G/B packed |
| prog_hi | input | 36 | Programmable upper bounds, R/G/B packed |
| out_valid | output | 1 | Output pixel is valid |
| out_pix | output | 36 | Clamped pixel, R/G/B packed |

## Verification
The bench tests values exactly at, one below and one above each fixed bound. Values are one LSB apart: 0xEB0 against 0xEB1, 0xEBC against 0xEBD, 0xEBF against 0xEC0. Off-by-one bounds or a swapped comparison would let such a value through or clip a legal one. Code 7 is used right after reset, before any load, which exposes wrong default bounds. Code 7 is then used with different bounds on each channel and with a crossed window. This catches swapped channel slices and a wrong order of the two bound tests. Spare codes, enable-low stimulus and gaps in valid are also applied. A decoder that clamps on unused codes, or an output register that loads on invalid cycles, shows up as a mismatch on the affected pixel.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    typedef enum logic [2:0] {
        MODE_PASS  = 3'd0,
        MODE_FIX8  = 3'd1,
        MODE_FIX10 = 3'd2,
        MODE_FIX12 = 3'd3,
        MODE_PROG  = 3'd4
    } clamp_mode_e;

    // lower edge of the limited video window, left-aligned in comp_w bits
    function automatic int fix_lo(input int comp_w);
        return 16 << (comp_w - 8);
    endfunction

    // upper edge: 235 left-aligned, low bits of the deeper code set to ones
    function automatic int fix_hi(input int depth, input int comp_w);
        return (235 << (comp_w - 8)) | (((1 << (depth - 8)) - 1) << (comp_w - depth));
    endfunction

endpackage

// File: rtl/clamp_mode_decode.sv
module clamp_mode_decode
    import clamp_pkg::*;
(
    input  logic        enable,
    input  logic [2:0]  code,
    output clamp_mode_e mode
);

    always_comb begin
        mode = MODE_PASS;
        if (enable) begin
            unique case (code)
                3'd1:    mode = MODE_FIX8;
                3'd2:    mode = MODE_FIX10;
                3'd3:    mode = MODE_FIX12;
                3'd7:    mode = MODE_PROG;
                default: mode = MODE_PASS;
            endcase
        end
    end

endmodule

// File: rtl/clamp_bound_regs.sv
module clamp_bound_regs #(
    parameter int COMP_W = 12,
    parameter int NUM_CH = 3,
    parameter int RST_LO = 16,
    parameter int RST_HI = 4079,
    localparam int BUS_W = COMP_W * NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] lo_in,
    input  logic [BUS_W-1:0] hi_in,
    output logic [BUS_W-1:0] lo_q,
    output logic [BUS_W-1:0] hi_q
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[c*COMP_W +: COMP_W] <= COMP_W'(RST_LO);
                hi_q[c*COMP_W +: COMP_W] <= COMP_W'(RST_HI);
            end else if (load) begin
                lo_q[c*COMP_W +: COMP_W] <= lo_in[c*COMP_W +: COMP_W];
                hi_q[c*COMP_W +: COMP_W] <= hi_in[c*COMP_W +: COMP_W];
            end
        end
    end

    assert_bound_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (lo_q == $past(lo_in) && hi_q == $past(hi_in)));

    assert_bound_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> $stable(lo_q) && $stable(hi_q));

endmodule

// File: rtl/clamp_bound_sel.sv
module clamp_bound_sel
    import clamp_pkg::*;
#(
    parameter int COMP_W = 12,
    parameter int NUM_CH = 3,
    localparam int BUS_W = COMP_W * NUM_CH
) (
    input  clamp_mode_e      mode,
    input  logic [BUS_W-1:0] prog_lo,
    input  logic [BUS_W-1:0] prog_hi,
    output logic [BUS_W-1:0] sel_lo,
    output logic [BUS_W-1:0] sel_hi,
    output logic             active
);

    localparam logic [COMP_W-1:0] LO_FIX  = COMP_W'(fix_lo(COMP_W));
    localparam logic [COMP_W-1:0] HI_FIX8 = COMP_W'(fix_hi(8, COMP_W));
    localparam logic [COMP_W-1:0] HI_FIX10 = COMP_W'(fix_hi(10, COMP_W));
    localparam logic [COMP_W-1:0] HI_FIX12 = COMP_W'(fix_hi(12, COMP_W));

    logic [COMP_W-1:0] fixed_hi;

    always_comb begin
        active   = 1'b1;
        fixed_hi = HI_FIX12;
        unique case (mode)
            MODE_PASS:  active = 1'b0;
            MODE_FIX8:  fixed_hi = HI_FIX8;
            MODE_FIX10: fixed_hi = HI_FIX10;
            MODE_FIX12: fixed_hi = HI_FIX12;
            MODE_PROG:  fixed_hi = HI_FIX12;
            default:    active = 1'b0;
        endcase
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            if (mode == MODE_PROG) begin
                sel_lo[c*COMP_W +: COMP_W] = prog_lo[c*COMP_W +: COMP_W];
                sel_hi[c*COMP_W +: COMP_W] = prog_hi[c*COMP_W +: COMP_W];
            end else begin
                sel_lo[c*COMP_W +: COMP_W] = LO_FIX;
                sel_hi[c*COMP_W +: COMP_W] = fixed_hi;
            end
        end
    end

endmodule

// File: rtl/clamp_channel.sv
module clamp_channel #(
    parameter int COMP_W = 12
) (
    input  logic              active,
    input  logic [COMP_W-1:0] x,
    input  logic [COMP_W-1:0] lo,
    input  logic [COMP_W-1:0] hi,
    output logic [COMP_W-1:0] y
);

    always_comb begin
        if (!active)      y = x;
        else if (x < lo)  y = lo;
        else if (x > hi)  y = hi;
        else              y = x;
    end

    always_comb begin
        if (active && lo <= hi)
            assert_in_window_R7: assert (y >= lo && y <= hi);
    end

endmodule

// File: rtl/pixel_range_clamp.sv
module pixel_range_clamp
    import clamp_pkg::*;
#(
    parameter int COMP_W = 12,
    parameter int NUM_CH = 3,
    localparam int BUS_W = COMP_W * NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] in_pix,
    input  logic             clamp_en,
    input  logic [2:0]       fmt_code,
    input  logic             prog_load,
    input  logic [BUS_W-1:0] prog_lo,
    input  logic [BUS_W-1:0] prog_hi,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_pix
);

    clamp_mode_e      mode;
    logic [BUS_W-1:0] reg_lo, reg_hi;
    logic [BUS_W-1:0] win_lo, win_hi;
    logic             win_active;
    logic [BUS_W-1:0] clamped;

    clamp_mode_decode u_decode (
        .enable (clamp_en),
        .code   (fmt_code),
        .mode   (mode)
    );

    clamp_bound_regs #(.COMP_W(COMP_W), .NUM_CH(NUM_CH)) u_bounds (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (prog_load),
        .lo_in (prog_lo),
        .hi_in (prog_hi),
        .lo_q  (reg_lo),
        .hi_q  (reg_hi)
    );

    clamp_bound_sel #(.COMP_W(COMP_W), .NUM_CH(NUM_CH)) u_sel (
        .mode    (mode),
        .prog_lo (reg_lo),
        .prog_hi (reg_hi),
        .sel_lo  (win_lo),
        .sel_hi  (win_hi),
        .active  (win_active)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        clamp_channel #(.COMP_W(COMP_W)) u_ch (
            .active (win_active),
            .x      (in_pix[c*COMP_W +: COMP_W]),
            .lo     (win_lo[c*COMP_W +: COMP_W]),
            .hi     (win_hi[c*COMP_W +: COMP_W]),
            .y      (clamped[c*COMP_W +: COMP_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_pix <= clamped;
        end
    end

    assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && !clamp_en) |-> out_pix == $past(in_pix));

    assert_spare_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && clamp_en && fmt_code >= 3'd4 && fmt_code <= 3'd6)
        |-> out_pix == $past(in_pix));

    assert_fix8_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && clamp_en && fmt_code == 3'd1)
        |-> (out_pix[COMP_W-1:0] >= COMP_W'(fix_lo(COMP_W))
             && out_pix[COMP_W-1:0] <= COMP_W'(fix_hi(8, COMP_W))));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(out_pix));

endmodule

// File: tb/pixel_range_clamp_tb.sv
module pixel_range_clamp_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [35:0] in_pix = '0;
    logic        clamp_en = 1'b0;
    logic [2:0]  fmt_code = '0;
    logic        prog_load = 1'b0;
    logic [35:0] prog_lo = '0;
    logic [35:0] prog_hi = '0;
    logic        out_valid;
    logic [35:0] out_pix;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    bit live = 0;

    always #4 clk = ~clk;

    pixel_range_clamp u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .clamp_en(clamp_en), .fmt_code(fmt_code), .prog_load(prog_load),
        .prog_lo(prog_lo), .prog_hi(prog_hi), .out_valid(out_valid), .out_pix(out_pix)
    );

    // behavioural reference
    logic [11:0] m_lo [3];
    logic [11:0] m_hi [3];
    logic        exp_v;
    logic [35:0] exp_pix;
    string       exp_tag;

    function automatic logic [11:0] lim(input logic [11:0] x, input logic [11:0] lo, input logic [11:0] hi);
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin m_lo[c] = 12'h010; m_hi[c] = 12'hFEF; end
            exp_v = 1'b0; exp_pix = '0; exp_tag = "R8";
        end else begin
            exp_v = in_valid;
            if (!in_valid) exp_tag = "R9";
            else begin
                for (int c = 0; c < 3; c++) begin
                    logic [11:0] x;
                    logic [11:0] y;
                    x = in_pix[c*12 +: 12];
                    y = x;
                    if (!clamp_en) exp_tag = "R5";
                    else case (fmt_code)
                        3'd0: exp_tag = "R1";
                        3'd1: begin y = lim(x, 12'h100, 12'hEB0); exp_tag = "R2"; end
                        3'd2: begin y = lim(x, 12'h100, 12'hEBC); exp_tag = "R2"; end
                        3'd3: begin y = lim(x, 12'h100, 12'hEBF); exp_tag = "R2"; end
                        3'd7: begin y = lim(x, m_lo[c], m_hi[c]); exp_tag = "R3/R7"; end
                        default: exp_tag = "R6";
                    endcase
                    exp_pix[c*12 +: 12] = y;
                end
            end
            if (prog_load)
                for (int c = 0; c < 3; c++) begin
                    m_lo[c] = prog_lo[c*12 +: 12];
                    m_hi[c] = prog_hi[c*12 +: 12];
                end
            live = 1;
        end
    end

    always @(negedge clk) begin
        if (live && rst_n && !done) begin
            checks++;
            if (out_valid !== exp_v) begin
                errors++;
                $display("FAIL R8 out_valid: actual %0b expected %0b", out_valid, exp_v);
            end
            checks++;
            if (out_pix !== exp_pix) begin
                errors++;
                $display("FAIL %s out_pix: actual %h expected %h", exp_tag, out_pix, exp_pix);
            end
        end
    end

    task automatic finish_up();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic px(input bit v, input bit en, input logic [2:0] code, input logic [11:0] r,
                      input logic [11:0] g, input logic [11:0] b);
        @(negedge clk);
        in_valid = v; clamp_en = en; fmt_code = code; in_pix = {r, g, b};
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                errors++;
                $display("FAIL watchdog expired");
                finish_up();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_pix !== '0) begin
            errors++;
            $display("FAIL R8 reset state: actual %0b/%h expected 0/0", out_valid, out_pix);
        end
        rst_n = 1'b1;
        // R4: defaults before any load
        px(1, 1, 3'd7, 12'h000, 12'h00F, 12'hFFF);
        px(1, 1, 3'd7, 12'h010, 12'hFEF, 12'hFF0);
        // R1 / R5 / R6 pass-through
        px(1, 1, 3'd0, 12'h000, 12'hFFF, 12'h123);
        px(1, 0, 3'd1, 12'h000, 12'hFFF, 12'h005);
        px(1, 0, 3'd7, 12'hFFF, 12'h001, 12'hABC);
        for (int k = 4; k < 7; k++) px(1, 1, 3'(k), 12'h000, 12'hFFF, 12'h0FF);
        // R2 bound edges
        for (int k = 1; k < 4; k++) begin
            px(1, 1, 3'(k), 12'h0FF, 12'h100, 12'h101);
            px(1, 1, 3'(k), 12'hEB0, 12'hEB1, 12'hEBC);
            px(1, 1, 3'(k), 12'hEBD, 12'hEBF, 12'hEC0);
            px(1, 1, 3'(k), 12'h000, 12'hFFF, 12'h800);
        end
        // R9 gaps in valid
        px(0, 1, 3'd1, 12'hFFF, 12'hFFF, 12'hFFF);
        px(0, 0, 3'd0, 12'h000, 12'h000, 12'h000);
        // R3 per-channel load
        @(negedge clk);
        in_valid = 1; clamp_en = 1; fmt_code = 3'd7; in_pix = {12'h000, 12'h000, 12'h000};
        prog_load = 1; prog_lo = {12'h200, 12'h300, 12'h400}; prog_hi = {12'h500, 12'h600, 12'h700};
        @(negedge clk);
        prog_load = 0; in_pix = {12'h000, 12'h000, 12'h000};
        px(1, 1, 3'd7, 12'hFFF, 12'hFFF, 12'hFFF);
        px(1, 1, 3'd7, 12'h250, 12'h2FF, 12'h701);
        // R7 crossed window: lo 0x800 above hi 0x400
        @(negedge clk);
        in_valid = 0; prog_load = 1;
        prog_lo = {3{12'h800}}; prog_hi = {3{12'h400}};
        @(negedge clk);
        prog_load = 0;
        px(1, 1, 3'd7, 12'h100, 12'h600, 12'h900);
        // mixed random traffic
        for (int k = 0; k < 300; k++)
            px(1'($urandom), 1'($urandom), 3'($urandom), 12'($urandom), 12'($urandom), 12'($urandom));
        px(0, 0, 3'd0, 12'h0, 12'h0, 12'h0);
        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule